// File: doc/BRIEF.md
# Serial Shift Chain with Strobed Parallel Store

This block takes a serial bit stream into a chain of flip-flops, one bit per rising clock edge, and copies the chain into a separate parallel storage register whenever a strobe is sampled high. The stored word drives the parallel outputs through a pad stage that an output enable gates. The bit leaving the last stage is offered twice for cascading into a following chain. One copy updates on the rising edge. The other is retimed on the falling edge, so a downstream chain clocked slightly late still sees stable data.

The parallel outputs are modelled as a data bus with one enable for the whole bus. A parameter selects the pad variant. The default drives disabled pins to zero. The alternative drives them to high impedance. The chain keeps shifting and both cascade outputs keep updating while the parallel pins are disabled. A synchronous active-low reset clears all state and exists only for simulation.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising clock edge the serial input enters stage 0 and every other stage takes the old value of the stage below it. A bit therefore appears on `ser_rise` after STAGES rising edges.
- R2: When `strobe` is sampled low on a rising edge, `par_data` keeps its previous value.
- R3: When `strobe` is sampled high on a rising edge, `par_data` takes the post-shift chain contents. Bit 0 is the serial input of that edge, and bit n is the old value of chain stage n-1.
- R4: When `out_en` is low, `par_en` is low. In the default pad mode (0) every `par_pins` bit reads 0. In pad mode 1 the pins are high impedance. This holds whatever the clock and strobe do.
- R5: Shifting and strobed loading continue while `out_en` is low.
- R6: `ser_fall` changes only on falling clock edges, where it takes the last-stage value. It lags `ser_rise` by half a clock period and holds across rising edges.
- R7: `ser_rise` updates on the rising edge with the value shifted into the last stage. Neither cascade output depends on `out_en`.
- R8: A rising edge with `rst_n` low clears the chain and the store. A falling edge with `rst_n` low clears `ser_fall`. All outputs then read zero.
- R9: When `out_en` is high, `par_en` is high and `par_pins` equals `par_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The chain moves on the rising edge; `ser_fall` updates on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset, for simulation only |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | Loads the store from the post-shift chain when sampled high |
| out_en | input | 1 | Enables the parallel pins |
| par_pins | output | STAGES | Parallel pins after the pad stage |
| par_data | output | STAGES | Storage register contents, not gated |
| par_en | output | 1 | Bus enable for an external tri-state buffer |
| ser_rise | output | 1 | Cascade output from the last stage, updated on the rising edge |
| ser_fall | output | 1 | Cascade output, last stage retimed on the falling edge |

## Verification
Several properties are checked on every clock edge. The store holds while the strobe is low and loads its end bits correctly when the strobe is high. The pins follow the store when enabled and are blocked when disabled. On each falling edge, `ser_fall` picks up the `ser_rise` value seen one falling edge earlier. Some behaviour cannot be stated as a short property and only the bench's reference model can show it. This covers full-word agreement after a strobe, the STAGES-edge delay from `ser_in` to `ser_rise`, and shifting that continues through long disabled stretches. It also covers reset in the middle of a run and the half-period lag sampled between the edges.

// File: rtl/ssr_pkg.sv
// Package: shared parameters and types for the shift-and-store block.
// Assumes: nothing beyond a single clock domain.
package ssr_pkg;
    // Default chain length
    localparam int SSR_DEF_STAGES = 8;

    // Pad behaviour when the parallel bus is disabled
    typedef enum logic {
        PAD_GATED_ZERO = 1'b0,
        PAD_TRISTATE   = 1'b1
    } pad_mode_e;
endpackage

// File: rtl/ssr_shift_chain.sv
// Module: serial-in shift chain. On each rising edge ser_in enters stage 0
// and every stage n takes stage n-1. Also exposes the next-state value so a
// store can capture the post-shift contents on the same edge.
// Assumes: STAGES >= 2; synchronous active-low reset.
module ssr_shift_chain #(
    parameter int STAGES = ssr_pkg::SSR_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] chain_q,
    output logic [STAGES-1:0] chain_next
);
    localparam int TOP = STAGES - 1;

    // Purpose: form the post-shift contents of the chain
    always_comb begin
        chain_next = {chain_q[TOP-1:0], ser_in};
    end

    // Purpose: advance the chain on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_next;
    end
endmodule

// File: rtl/ssr_store.sv
// Module: parallel storage register. Captures its input on a rising edge
// whenever load is sampled high, otherwise holds. It stands in for a
// level-transparent latch using a synchronous register.
// Assumes: synchronous active-low reset.
module ssr_store #(
    parameter int STAGES = ssr_pkg::SSR_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);
    // Purpose: load or hold the stored word
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ssr_fall_tap.sv
// Module: falling-edge retiming flop for the cascade bit. It gives a
// downstream chain half a period of extra hold margin.
// Assumes: rst_n is sampled on the falling edge too (synchronous reset).
module ssr_fall_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Purpose: capture the last-stage bit on the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/ssr_pad.sv
// Module: parallel pad stage. Presents data on the pins when enabled. When
// disabled it drives zeros or high impedance, depending on PAD_MODE.
// Assumes: one enable covers the whole bus.
module ssr_pad #(
    parameter int               STAGES   = ssr_pkg::SSR_DEF_STAGES,
    parameter ssr_pkg::pad_mode_e PAD_MODE = ssr_pkg::PAD_GATED_ZERO
) (
    input  logic              en,
    input  logic [STAGES-1:0] data,
    output logic [STAGES-1:0] pins,
    output logic              bus_en
);
    assign bus_en = en;

    generate
        if (PAD_MODE == ssr_pkg::PAD_TRISTATE) begin : g_tri
            // Purpose: release the pins when disabled
            assign pins = en ? data : {STAGES{1'bz}};
        end else begin : g_zero
            // Purpose: force the pins low when disabled
            assign pins = en ? data : '0;
        end
    endgenerate
endmodule

// File: rtl/shift_store_reg.sv
// Module: top level of the shift-and-store block. It wires the shift chain,
// the strobed store, the falling-edge cascade tap and the pad stage.
// Assumes: a single clock; the store captures the post-shift chain.
module shift_store_reg #(
    parameter int                 STAGES   = ssr_pkg::SSR_DEF_STAGES,
    parameter ssr_pkg::pad_mode_e PAD_MODE = ssr_pkg::PAD_GATED_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_pins,
    output logic [STAGES-1:0] par_data,
    output logic              par_en,
    output logic              ser_rise,
    output logic              ser_fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_next;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .chain_q    (chain_q),
        .chain_next (chain_next)
    );

    ssr_store #(.STAGES(STAGES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .d     (chain_next),
        .q     (par_data)
    );

    // Purpose: the rising-edge cascade output is the last stage itself
    assign ser_rise = chain_q[TOP];

    ssr_fall_tap u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chain_q[TOP]),
        .q     (ser_fall)
    );

    ssr_pad #(.STAGES(STAGES), .PAD_MODE(PAD_MODE)) u_pad (
        .en     (out_en),
        .data   (par_data),
        .pins   (par_pins),
        .bus_en (par_en)
    );
endmodule

// File: rtl/ssr_checker.sv
// Module: property checker for shift_store_reg. It is attached by bind and
// watches ports only.
// Assumes: the same parameters as the bound instance.
module ssr_checker #(
    parameter int                 STAGES   = ssr_pkg::SSR_DEF_STAGES,
    parameter ssr_pkg::pad_mode_e PAD_MODE = ssr_pkg::PAD_GATED_ZERO
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_in,
    input logic              strobe,
    input logic              out_en,
    input logic [STAGES-1:0] par_pins,
    input logic [STAGES-1:0] par_data,
    input logic              par_en,
    input logic              ser_rise,
    input logic              ser_fall
);
    localparam int TOP = STAGES - 1;
    localparam bit ZERO_PAD = (PAD_MODE == ssr_pkg::PAD_GATED_ZERO);

    assert_store_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(strobe)) |-> (par_data == $past(par_data)));

    assert_store_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strobe)) |->
            ((par_data[0] == $past(ser_in)) && (par_data[TOP] == ser_rise)));

    assert_pins_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!par_en && (!ZERO_PAD || par_pins == '0)));

    assert_pins_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (par_en && par_pins == par_data));

    assert_fall_lag_R6: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ser_fall == $past(ser_rise)));
endmodule

bind shift_store_reg ssr_checker #(.STAGES(STAGES), .PAD_MODE(PAD_MODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .strobe   (strobe),
    .out_en   (out_en),
    .par_pins (par_pins),
    .par_data (par_data),
    .par_en   (par_en),
    .ser_rise (ser_rise),
    .ser_fall (ser_fall)
);

// File: tb/sim_shift_store_reg.sv
// Bench: a reference model driven by directed and seeded random stimulus.
module sim_shift_store_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b0;
    logic         strobe = 1'b0;
    logic         out_en = 1'b0;
    logic [W-1:0] par_pins;
    logic [W-1:0] par_data;
    logic         par_en;
    logic         ser_rise;
    logic         ser_fall;

    int n_cmp = 0;
    int n_bad = 0;

    logic [W-1:0] m_chain = '0;
    logic [W-1:0] m_store = '0;
    logic         m_fall  = 1'b0;

    always #5 clk = ~clk;

    shift_store_reg #(.STAGES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
        .out_en(out_en), .par_pins(par_pins), .par_data(par_data),
        .par_en(par_en), .ser_rise(ser_rise), .ser_fall(ser_fall)
    );

    function automatic logic [W-1:0] shifted(input logic [W-1:0] c, input logic d);
        return {c[W-2:0], d};
    endfunction

    function automatic logic [W-1:0] pins_exp(input logic en, input logic [W-1:0] s);
        return en ? s : '0;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Applies inputs, then checks after the rising edge and after the falling edge
    task automatic step(input logic r, input logic d, input logic s, input logic o);
        rst_n = r; ser_in = d; strobe = s; out_en = o;
        @(posedge clk); #1;
        if (!r) begin
            m_chain = '0; m_store = '0;
        end else begin
            m_chain = shifted(m_chain, d);
            if (s) m_store = m_chain;
        end
        chk("R1/R5/R7 ser_rise", {{(W-1){1'b0}}, ser_rise}, {{(W-1){1'b0}}, m_chain[W-1]});
        chk(s ? "R3 par_data load" : "R2 par_data hold", par_data, m_store);
        chk(o ? "R9 par_en" : "R4 par_en", {{(W-1){1'b0}}, par_en}, {{(W-1){1'b0}}, o});
        chk(o ? "R9 par_pins" : "R4 par_pins", par_pins, pins_exp(o, m_store));
        chk("R6 ser_fall holds at rising edge", {{(W-1){1'b0}}, ser_fall}, {{(W-1){1'b0}}, m_fall});
        @(negedge clk); #1;
        m_fall = r ? m_chain[W-1] : 1'b0;
        chk("R6/R7 ser_fall after falling edge", {{(W-1){1'b0}}, ser_fall}, {{(W-1){1'b0}}, m_fall});
    endtask

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pat;
        void'($urandom(32'd20240917));
        #1;
        // R8: reset clears everything
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 reset par_data", par_data, '0);
        chk("R8 reset ser_rise/ser_fall", {{(W-2){1'b0}}, ser_rise, ser_fall}, '0);

        // R1/R2: shift a known pattern with strobe low; store holds zero
        pat = 8'hA5;
        for (int i = W - 1; i >= 0; i--) step(1'b1, pat[i], 1'b0, 1'b1);
        chk("R2 store held during shifting", par_data, '0);
        // R1: the pattern's first bit reaches ser_rise after W edges
        chk("R1 first pattern bit on ser_rise", {{(W-1){1'b0}}, ser_rise}, {{(W-1){1'b0}}, pat[W-1]});

        // R3: strobe pulse loads the post-shift word
        step(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R3 strobed word", par_data, shifted(pat, 1'b0));

        // R4/R5: disabled pins, chain keeps shifting and the store keeps loading
        for (int i = 0; i < W; i++) step(1'b1, i[0], 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 load while disabled visible", par_data, m_store);

        // R8: reset in the middle of a run
        step(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R8 mid-run reset store", par_data, '0);

        // Seeded random mix
        for (int i = 0; i < 400; i++) begin
            logic rr;
            rr = ($urandom % 50) != 0;
            step(rr, 1'($urandom), ($urandom % 4) == 0, ($urandom % 3) != 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule